// File: doc/BRIEF.md
# Panel Self-Refresh State Sequencer

This block walks a display source through the states of panel self-refresh. Software controls it through a few one-cycle command pulses: turn the feature on, arm or disarm entry into self-refresh, request a single update frame, and turn the feature off. The block then moves between six states. Some moves wait for a software command. Others happen on their own, once the link layer acknowledges that its work is done.

Before it enters self-refresh, the block counts idle frames. It counts frame strobes while it is enabled but not yet refreshing. When the count reaches a threshold derived from a configured value, it starts entry. The link layer is only modelled here. The block raises a one-cycle request to send a static frame, a single update frame or a wake-up message, and it waits for the matching acknowledge pulse. The current state, an in-transition flag and an active flag are outputs.

Top module: `srf_sequencer`

## Requirements
- R1: After reset, `state` is 0 (disabled). `in_trans`, `active`, `sfu_pending` and all three send strobes are 0.
- R2: The state codes are 0 disabled, 1 inactive, 2 entering (static frame being sent), 3 active (no remote buffer update), 4 active with a single-frame update, and 5 exit. A `set_enable` pulse in state 0 moves the block to state 1.
- R3: The idle threshold depends on `cfg_idle`. If `cfg_idle` is zero, the threshold is 5. Otherwise it is `cfg_idle` + 1. When `cfg_no_retrain` is 1, 4 is added to the threshold.
- R4: The idle counter counts `frame_strobe` pulses only in state 1. A `frame_changed` pulse in state 1 sets it back to zero. Strobes in any other state are not counted.
- R5: In state 1, with entry armed (by `set_entry`), reaching the threshold moves the block to state 2. Entering state 2 raises `send_static` for one cycle. A `static_ack` pulse then moves the block to state 3.
- R6: A `clr_entry` pulse in state 3 moves the block straight to state 5, skipping state 4. Entering state 5 raises `send_wake` for one cycle. A `wake_ack` pulse returns the block to state 1.
- R7: A `frame_changed` pulse in state 3 with no single-frame request pending moves the block to state 5. Entry stays armed, so the block re-enters after a fresh idle count.
- R8: `set_sfu` while enabled sets `sfu_pending`. While the block is disabled, `set_sfu` is ignored. In state 3, `frame_changed` with `sfu_pending` set moves the block to state 4 and raises `send_update` for one cycle. `update_ack` returns the block to state 3 and clears `sfu_pending` by itself.
- R9: `active` is 1 exactly in states 3 and 4. `in_trans` is 1 exactly in states 2, 4 and 5.
- R10: A `disable_req` pulse while `in_trans` is 1 is ignored. Otherwise it moves the block to state 0 and clears enable, entry and any pending single-frame request. After that, a `set_enable` pulse alone gives state 1 with entry not armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_enable | input | 1 | Pulse: turn the feature on |
| set_entry | input | 1 | Pulse: arm entry into self-refresh |
| clr_entry | input | 1 | Pulse: disarm entry, leaves active state |
| set_sfu | input | 1 | Pulse: request one single update frame |
| disable_req | input | 1 | Pulse: turn the feature off |
| frame_strobe | input | 1 | One pulse per frame |
| frame_changed | input | 1 | Frame content changed |
| cfg_idle | input | IDLE_W | Configured idle-frame value |
| cfg_no_retrain | input | 1 | Sink needs no retraining on exit |
| static_ack | input | 1 | Link layer finished static-frame entry |
| update_ack | input | 1 | Link layer finished the update frame |
| wake_ack | input | 1 | Link layer finished the wake-up |
| state | output | 3 | Current state code |
| in_trans | output | 1 | Transition in progress |
| active | output | 1 | Self-refresh active |
| sfu_pending | output | 1 | Single-frame request outstanding |
| send_static | output | 1 | Strobe: send static frame |
| send_update | output | 1 | Strobe: send single update frame |
| send_wake | output | 1 | Strobe: send wake-up |

## Verification
The idle-entry path is swept over every `cfg_idle` value from 0 to 7, each with and without `cfg_no_retrain`. After each frame strobe the state is checked, so an off-by-one in the threshold, or a missing zero case, shows up as entry one frame early or late. The sweep alternates the two ways out of state 3: disarming entry, or a frame change. This separates the exit that keeps entry armed from the one that clears it. Further patterns cover:
- strobes sent while disabled, and a frame change part-way through counting, which show whether the counter is gated and reset correctly;
- a disable attempted during a transition, which must leave the state unchanged;
- a single-frame request issued while disabled, which must be dropped.

// File: rtl/srf_pkg.sv
package srf_pkg;
  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_IDLE   = 3'd1,
    ST_ENTER  = 3'd2,
    ST_ACTIVE = 3'd3,
    ST_SFU    = 3'd4,
    ST_EXIT   = 3'd5
  } srf_state_e;

  localparam int unsigned DEFAULT_THR = 5;
  localparam int unsigned RETRAIN_ADD = 4;
endpackage

// File: rtl/srf_idle_counter.sv
module srf_idle_counter #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             count_en,
  input  logic             frame_strobe,
  input  logic             frame_changed,
  input  logic [CNT_W-1:0] thr,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!count_en || frame_changed) cnt_d = '0;
    else if (frame_strobe && (cnt_q < thr)) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q >= thr);

  // R4
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && frame_changed) |=> (cnt_q == '0));

  // R4
  cnt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_en) |=> (cnt_q == '0));
endmodule

// File: rtl/srf_ctl_regs.sv
module srf_ctl_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic set_enable,
  input  logic set_entry,
  input  logic clr_entry,
  input  logic set_sfu,
  input  logic dis_accept,
  input  logic sfu_done,
  output logic en_q,
  output logic entry_q,
  output logic sfu_q
);
  logic en_d, entry_d, sfu_d;

  always_comb begin
    en_d    = en_q;
    entry_d = entry_q;
    sfu_d   = sfu_q;
    if (set_enable) en_d = 1'b1;
    if (set_entry)  entry_d = 1'b1;
    if (clr_entry)  entry_d = 1'b0;
    if (set_sfu && en_q) sfu_d = 1'b1;
    if (sfu_done)   sfu_d = 1'b0;
    if (dis_accept) begin
      en_d    = 1'b0;
      entry_d = 1'b0;
      sfu_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      entry_q <= 1'b0;
      sfu_q   <= 1'b0;
    end else begin
      en_q    <= en_d;
      entry_q <= entry_d;
      sfu_q   <= sfu_d;
    end
  end

  // R8
  sfu_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !sfu_q && !set_enable) |=> !sfu_q);
endmodule

// File: rtl/srf_sequencer.sv
module srf_sequencer
  import srf_pkg::*;
#(
  parameter int unsigned IDLE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_enable,
  input  logic              set_entry,
  input  logic              clr_entry,
  input  logic              set_sfu,
  input  logic              disable_req,
  input  logic              frame_strobe,
  input  logic              frame_changed,
  input  logic [IDLE_W-1:0] cfg_idle,
  input  logic              cfg_no_retrain,
  input  logic              static_ack,
  input  logic              update_ack,
  input  logic              wake_ack,
  output logic [2:0]        state,
  output logic              in_trans,
  output logic              active,
  output logic              sfu_pending,
  output logic              send_static,
  output logic              send_update,
  output logic              send_wake
);
  localparam int unsigned CNT_W = IDLE_W + 2;

  srf_state_e st_q, st_d;
  logic en_q, entry_q, sfu_q;
  logic dis_accept, sfu_done, idle_done;
  logic [CNT_W-1:0] thr;
  logic strobe_static_q, strobe_update_q, strobe_wake_q;

  // idle threshold from the configured value
  always_comb begin
    if (cfg_idle == '0) thr = CNT_W'(DEFAULT_THR);
    else                thr = CNT_W'(cfg_idle) + 1'b1;
    if (cfg_no_retrain) thr = thr + CNT_W'(RETRAIN_ADD);
  end

  assign in_trans   = (st_q == ST_ENTER) || (st_q == ST_SFU) || (st_q == ST_EXIT);
  assign dis_accept = disable_req && !in_trans;
  assign sfu_done   = (st_q == ST_SFU) && update_ack;

  srf_ctl_regs u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_enable (set_enable),
    .set_entry  (set_entry),
    .clr_entry  (clr_entry),
    .set_sfu    (set_sfu),
    .dis_accept (dis_accept),
    .sfu_done   (sfu_done),
    .en_q       (en_q),
    .entry_q    (entry_q),
    .sfu_q      (sfu_q)
  );

  srf_idle_counter #(.CNT_W(CNT_W)) u_idle (
    .clk           (clk),
    .rst_n         (rst_n),
    .count_en      (st_q == ST_IDLE),
    .frame_strobe  (frame_strobe),
    .frame_changed (frame_changed),
    .thr           (thr),
    .done          (idle_done)
  );

  always_comb begin
    st_d = st_q;
    if (dis_accept) begin
      st_d = ST_OFF;
    end else begin
      case (st_q)
        ST_OFF:    if (en_q) st_d = ST_IDLE;
        ST_IDLE:   if (entry_q && idle_done) st_d = ST_ENTER;
        ST_ENTER:  if (static_ack) st_d = ST_ACTIVE;
        ST_ACTIVE: begin
          if (!entry_q)                    st_d = ST_EXIT;
          else if (frame_changed && sfu_q) st_d = ST_SFU;
          else if (frame_changed)          st_d = ST_EXIT;
        end
        ST_SFU:    if (update_ack) st_d = ST_ACTIVE;
        ST_EXIT:   if (wake_ack) st_d = ST_IDLE;
        default:   st_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q            <= ST_OFF;
      strobe_static_q <= 1'b0;
      strobe_update_q <= 1'b0;
      strobe_wake_q   <= 1'b0;
    end else begin
      st_q            <= st_d;
      strobe_static_q <= (st_d == ST_ENTER) && (st_q != ST_ENTER);
      strobe_update_q <= (st_d == ST_SFU)   && (st_q != ST_SFU);
      strobe_wake_q   <= (st_d == ST_EXIT)  && (st_q != ST_EXIT);
    end
  end

  assign state       = st_q;
  assign active      = (st_q == ST_ACTIVE) || (st_q == ST_SFU);
  assign sfu_pending = sfu_q;
  assign send_static = strobe_static_q;
  assign send_update = strobe_update_q;
  assign send_wake   = strobe_wake_q;

  // R5
  active_entry_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE || st_q == ST_OFF || st_q == ST_EXIT) |=> (st_q != ST_ACTIVE));

  // R6
  exit_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_ACTIVE && st_q != ST_EXIT) |=> (st_q != ST_EXIT));

  // R10
  disable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disable_req && in_trans) |=> (st_q != ST_OFF));

  // R8
  sfu_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SFU && update_ack && !set_sfu) |=> !sfu_pending);

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({send_static, send_update, send_wake}));

  // R6
  wake_on_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == ST_EXIT) |-> send_wake);
endmodule

// File: tb/srf_sequencer_tb_top.sv
`timescale 1ns/1ps
module srf_sequencer_tb_top;
  localparam int IDLE_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic set_enable = 0, set_entry = 0, clr_entry = 0, set_sfu = 0, disable_req = 0;
  logic frame_strobe = 0, frame_changed = 0, cfg_no_retrain = 0;
  logic static_ack = 0, update_ack = 0, wake_ack = 0;
  logic [IDLE_W-1:0] cfg_idle = '0;
  logic [2:0] state;
  logic in_trans, active, sfu_pending, send_static, send_update, send_wake;

  int checks = 0, errors = 0;
  int n_static = 0, n_update = 0, n_wake = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  srf_sequencer #(.IDLE_W(IDLE_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .set_enable(set_enable), .set_entry(set_entry),
    .clr_entry(clr_entry), .set_sfu(set_sfu), .disable_req(disable_req),
    .frame_strobe(frame_strobe), .frame_changed(frame_changed),
    .cfg_idle(cfg_idle), .cfg_no_retrain(cfg_no_retrain),
    .static_ack(static_ack), .update_ack(update_ack), .wake_ack(wake_ack),
    .state(state), .in_trans(in_trans), .active(active),
    .sfu_pending(sfu_pending), .send_static(send_static),
    .send_update(send_update), .send_wake(send_wake)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      n_static += int'(send_static);
      n_update += int'(send_update);
      n_wake   += int'(send_wake);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req, input int exp);
    chk(int'(state) == exp, req, int'(state), exp);
  endtask

  // drive one-cycle pulse by code, then let it settle two cycles
  task automatic pulse(input int which);
    case (which)
      0: set_enable = 1;   1: set_entry = 1;   2: clr_entry = 1;
      3: set_sfu = 1;      4: disable_req = 1; 5: frame_strobe = 1;
      6: frame_changed = 1; 7: static_ack = 1; 8: update_ack = 1;
      default: wake_ack = 1;
    endcase
    step(1);
    {set_enable, set_entry, clr_entry, set_sfu, disable_req} = '0;
    {frame_strobe, frame_changed, static_ack, update_ack, wake_ack} = '0;
    step(2);
  endtask

  function automatic int exp_thr(input int c, input bit nr);
    return ((c == 0) ? 5 : c + 1) + (nr ? 4 : 0);
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int s0;
    step(3);
    // R1 reset state
    chk(state == 3'd0 && !in_trans && !active && !sfu_pending, "R1", int'(state), 0);
    chk({send_static, send_update, send_wake} == 3'b000, "R1", int'({send_static, send_update, send_wake}), 0);
    rst_n = 1'b1;
    step(2);

    // R3 R5 R6 R7 R9 R10 sweep over threshold configurations
    for (int c = 0; c < 8; c++) begin
      for (int nr = 0; nr < 2; nr++) begin
        int t;
        t = exp_thr(c, nr[0]);
        cfg_idle = IDLE_W'(c);
        cfg_no_retrain = nr[0];
        pulse(0);
        chk_state("R2", 1);
        pulse(1);
        s0 = n_static;
        for (int n = 1; n <= t; n++) begin
          pulse(5);
          chk_state("R3", (n >= t) ? 2 : 1);
        end
        chk(n_static == s0 + 1, "R5", n_static - s0, 1);
        chk(in_trans && !active, "R9", int'({in_trans, active}), 2);
        pulse(4);
        chk_state("R10", 2);
        pulse(7);
        chk_state("R5", 3);
        chk(active && !in_trans, "R9", int'({in_trans, active}), 1);
        s0 = n_wake;
        if (nr == 1) begin
          pulse(2);
          chk_state("R6", 5);
        end else begin
          pulse(6);
          chk_state("R7", 5);
        end
        chk(n_wake == s0 + 1, "R6", n_wake - s0, 1);
        chk(in_trans && !active, "R9", int'({in_trans, active}), 2);
        pulse(4);
        chk_state("R10", 5);
        pulse(9);
        chk_state("R6", 1);
        if (nr == 0) begin
          // R7 entry still armed: a fresh idle count re-enters
          for (int n = 1; n <= t; n++) pulse(5);
          chk_state("R7", 2);
          pulse(7);
          pulse(2);
          pulse(9);
        end
        pulse(4);
        chk_state("R10", 0);
        chk(!in_trans && !active, "R10", int'({in_trans, active}), 0);
        // R10 entry cleared by disable
        pulse(0);
        for (int n = 0; n < t + 2; n++) pulse(5);
        chk_state("R10", 1);
        pulse(4);
        chk_state("R10", 0);
      end
    end

    // R4 gated counting and reset by frame change (threshold 5)
    cfg_idle = '0;
    cfg_no_retrain = 0;
    for (int n = 0; n < 10; n++) pulse(5);
    pulse(0);
    pulse(1);
    for (int n = 0; n < 4; n++) pulse(5);
    chk_state("R4", 1);
    pulse(6);
    for (int n = 0; n < 4; n++) pulse(5);
    chk_state("R4", 1);
    pulse(5);
    chk_state("R4", 2);
    pulse(7);
    chk_state("R5", 3);

    // R8 single-frame update
    pulse(3);
    chk(sfu_pending == 1'b1, "R8", int'(sfu_pending), 1);
    s0 = n_update;
    pulse(6);
    chk_state("R8", 4);
    chk(n_update == s0 + 1, "R8", n_update - s0, 1);
    chk(in_trans && active, "R9", int'({in_trans, active}), 3);
    pulse(4);
    chk_state("R10", 4);
    pulse(8);
    chk_state("R8", 3);
    chk(sfu_pending == 1'b0, "R8", int'(sfu_pending), 0);
    pulse(4);
    chk_state("R10", 0);
    pulse(3);
    chk(sfu_pending == 1'b0, "R8", int'(sfu_pending), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule